// File: doc/BRIEF.md
# Operand-Coherent Reset Controller

This block gathers every reset cause of a processor subsystem and turns them into two internal reset outputs: a full reset that clears all state, and a peripheral-only reset that leaves configuration registers and processor state alone. The hardware causes are an external reset pin, a watchdog, a double bus fault and loss of clock, plus power-on through the block's own asynchronous reset. The peripheral-only reset comes from a reset instruction.

A hardware reset never cuts an operand transfer in half. If the bus is busy when the request arrives, the request waits for the end-of-operand strobe. A bus monitor bounds the wait and runs whether or not bus monitoring is otherwise enabled. The block drives the shared reset pin in open-drain fashion. It releases the pin two clocks before the internal reset ends, so that its own drive is not mistaken for an external assertion.

After power-on the block waits for the clock to be stable. It then counts 328 reference-clock ticks before it raises the lock indication.

Top module: `rstctl_top`

## Requirements
- R1: While `por_n` is low, `full_rst_o`, `periph_rst_o` and `ext_rst_drive_o` are 1 and `lock_o` is 0. After `por_n` is released, `full_rst_o` stays 1 while `lock_o` is 0, and it falls two clocks after `lock_o` rises.
- R2: `ref_tick_i` pulses are ignored until `clk_stable_i` has been sampled high. `lock_o` rises at the clock edge that samples the 328th tick after that.
- R3: A watchdog or double-bus-fault pulse sampled while the bus is idle (`bus_busy_i`=0) raises `full_rst_o` right after that same clock edge.
- R4: If `bus_busy_i` is 1 when a hardware request is taken, `full_rst_o` stays 0 until the edge that samples `opnd_end_i`=1, and rises right after it.
- R5: If no end strobe comes, the pending reset is applied after 8, 16, 32 or 64 clocks in the pending state, for `tmo_sel_i` = 0, 1, 2 or 3. No enable is needed for this timeout.
- R6: A hardware reset keeps `full_rst_o` at 1 for exactly 18 clocks: 16 clocks with the pin driven, then 2 clocks of gap. `periph_rst_o` is 1 whenever `full_rst_o` is 1.
- R7: `ext_rst_drive_o`=1 pulls the pin low and 0 releases it; the pin is never driven high. The pin is released for the last 2 clocks of every internal reset, and in those clocks its sensed level is ignored.
- R8: `ext_rst_in_n` low and `clk_loss_i` high pass through 2-flop synchronizers. With the bus idle, `full_rst_o` rises after the third edge that samples the source.
- R9: A `sw_rst_i` pulse in normal operation raises `periph_rst_o` for exactly 16 clocks. `full_rst_o` and `ext_rst_drive_o` stay 0 and `lock_o` keeps its value.
- R10: Once set, `lock_o` stays 1 through every reset other than power-on.
- R11: Hardware requests that arrive while a full reset is in progress are ignored; they do not lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| clk_stable_i | input | 1 | Clock source has settled |
| ref_tick_i | input | 1 | One pulse per reference clock period |
| ext_rst_in_n | input | 1 | Sensed level of the shared reset pin, asynchronous |
| wdog_rst_i | input | 1 | Watchdog reset request, synchronous |
| dbl_fault_i | input | 1 | Double bus fault request, synchronous |
| clk_loss_i | input | 1 | Loss-of-clock request, asynchronous |
| sw_rst_i | input | 1 | Reset instruction executed, synchronous |
| bus_busy_i | input | 1 | An operand transfer is in progress |
| opnd_end_i | input | 1 | Last bus cycle of the current operand completes |
| tmo_sel_i | input | 2 | Bus monitor timeout: 8 << value clocks |
| full_rst_o | output | 1 | Reset of all internal state |
| periph_rst_o | output | 1 | Peripheral-only reset |
| ext_rst_drive_o | output | 1 | 1 pulls the reset pin low |
| lock_o | output | 1 | Power-on count finished, clock locked |

## Verification
The hardest situation to reach is a pending reset in which the end-of-operand strobe and the bus-monitor expiry land on the same clock, or one clock apart. A synchronized source adds its own two-clock delay to that timing. The stimulus sets a random strobe delay against each of the four timeout selections, including the case where the delay equals the limit. It mixes pulsed and synchronized sources, and it checks the exact edge on which the reset starts against a bench formula. A watchdog pulse injected in the middle of every reset checks that the reset length never changes.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  typedef enum logic [2:0] {
    ST_POR_WAIT = 3'd0,
    ST_POR_CNT  = 3'd1,
    ST_RUN      = 3'd2,
    ST_PEND     = 3'd3,
    ST_ASSERT   = 3'd4,
    ST_GAP      = 3'd5
  } rst_state_e;

  localparam int unsigned TMO_SEL_W = 2;

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int unsigned            WIDTH   = 2,
  parameter int unsigned            STAGES  = 2,
  parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= chain_d;
    end

    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/rstctl_por_timer.sv
module rstctl_por_timer #(
  parameter int unsigned TICKS = 328
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick_i) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = run_i && tick_i && (cnt_q == CNT_W'(TICKS - 1));

endmodule

// File: rtl/rstctl_bus_mon.sv
module rstctl_bus_mon #(
  parameter int unsigned BASE  = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);

  localparam int unsigned MAX_LIM = BASE << ((1 << SEL_W) - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_LIM) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;
  logic             cnt_en;

  assign limit = CNT_W'(BASE) << sel_i;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!arm_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != limit) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = arm_i && (cnt_q == (limit - CNT_W'(1)));

endmodule

// File: rtl/rstctl_seq.sv
module rstctl_seq
  import rstctl_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 16,
  parameter int unsigned GAP_CYC  = 2,
  parameter int unsigned SW_HOLD  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_stable_i,
  input  logic       por_done_i,
  input  logic       hw_req_i,
  input  logic       sw_req_i,
  input  logic       bus_busy_i,
  input  logic       opnd_end_i,
  input  logic       tmo_expire_i,
  output rst_state_e st_o,
  output logic       full_rst_o,
  output logic       periph_rst_o,
  output logic       drive_o,
  output logic       lock_o
);

  localparam int unsigned PH_MAX = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam int unsigned SW_W   = $clog2(SW_HOLD + 1);

  rst_state_e      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [SW_W-1:0] sw_q, sw_d;
  logic            lock_q, lock_d;
  logic            in_timed;

  assign in_timed = (st_q == ST_ASSERT) || (st_q == ST_GAP);

  // next state
  always_comb begin
    st_d   = st_q;
    lock_d = lock_q;
    unique case (st_q)
      ST_POR_WAIT: if (clk_stable_i) st_d = ST_POR_CNT;
      ST_POR_CNT: begin
        if (por_done_i) begin
          st_d   = ST_GAP;
          lock_d = 1'b1;
        end
      end
      ST_RUN: begin
        if (hw_req_i) st_d = bus_busy_i ? ST_PEND : ST_ASSERT;
      end
      ST_PEND: begin
        if (opnd_end_i || tmo_expire_i || !bus_busy_i) st_d = ST_ASSERT;
      end
      ST_ASSERT: if (ph_q == PH_W'(HOLD_CYC - 1)) st_d = ST_GAP;
      ST_GAP:    if (ph_q == PH_W'(GAP_CYC - 1))  st_d = ST_RUN;
      default:   st_d = ST_POR_WAIT;
    endcase
  end

  // phase counter for timed states
  always_comb begin
    if (st_d != st_q)  ph_d = '0;
    else if (in_timed) ph_d = ph_q + PH_W'(1);
    else               ph_d = ph_q;
  end

  // peripheral-only reset stretcher
  always_comb begin
    sw_d = sw_q;
    if (sw_q != '0) begin
      sw_d = sw_q - SW_W'(1);
    end else if ((st_q == ST_RUN) && !hw_req_i && sw_req_i) begin
      sw_d = SW_W'(SW_HOLD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_POR_WAIT;
      ph_q   <= '0;
      sw_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      sw_q   <= sw_d;
      lock_q <= lock_d;
    end
  end

  assign st_o         = st_q;
  assign full_rst_o   = (st_q != ST_RUN) && (st_q != ST_PEND);
  assign drive_o      = (st_q == ST_POR_WAIT) || (st_q == ST_POR_CNT) || (st_q == ST_ASSERT);
  assign periph_rst_o = full_rst_o || (sw_q != '0);
  assign lock_o       = lock_q;

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int unsigned POR_TICKS   = 328,
  parameter int unsigned TMO_BASE    = 8,
  parameter int unsigned HOLD_CYC    = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SW_HOLD     = 16
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 clk_stable_i,
  input  logic                 ref_tick_i,
  input  logic                 ext_rst_in_n,
  input  logic                 wdog_rst_i,
  input  logic                 dbl_fault_i,
  input  logic                 clk_loss_i,
  input  logic                 sw_rst_i,
  input  logic                 bus_busy_i,
  input  logic                 opnd_end_i,
  input  logic [TMO_SEL_W-1:0] tmo_sel_i,
  output logic                 full_rst_o,
  output logic                 periph_rst_o,
  output logic                 ext_rst_drive_o,
  output logic                 lock_o
);

  // the pin release gap equals the synchronizer depth so that
  // the block's own drive has left the sense path before it is looked at
  localparam int unsigned GAP_CYC = SYNC_STAGES;

  rst_state_e st;
  logic [1:0] async_src;
  logic [1:0] sync_src;
  logic       hw_req;
  logic       por_done;
  logic       tmo_expire;

  assign async_src = {clk_loss_i, ext_rst_in_n};

  rstctl_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b01)
  ) i_sync (
    .clk  (clk),
    .rst_n(por_n),
    .d_i  (async_src),
    .q_o  (sync_src)
  );

  assign hw_req = wdog_rst_i | dbl_fault_i | ~sync_src[0] | sync_src[1];

  rstctl_por_timer #(
    .TICKS(POR_TICKS)
  ) i_por_timer (
    .clk   (clk),
    .rst_n (por_n),
    .run_i (st == ST_POR_CNT),
    .tick_i(ref_tick_i),
    .done_o(por_done)
  );

  rstctl_bus_mon #(
    .BASE (TMO_BASE),
    .SEL_W(TMO_SEL_W)
  ) i_bus_mon (
    .clk     (clk),
    .rst_n   (por_n),
    .arm_i   (st == ST_PEND),
    .sel_i   (tmo_sel_i),
    .expire_o(tmo_expire)
  );

  rstctl_seq #(
    .HOLD_CYC(HOLD_CYC),
    .GAP_CYC (GAP_CYC),
    .SW_HOLD (SW_HOLD)
  ) i_seq (
    .clk         (clk),
    .rst_n       (por_n),
    .clk_stable_i(clk_stable_i),
    .por_done_i  (por_done),
    .hw_req_i    (hw_req),
    .sw_req_i    (sw_rst_i),
    .bus_busy_i  (bus_busy_i),
    .opnd_end_i  (opnd_end_i),
    .tmo_expire_i(tmo_expire),
    .st_o        (st),
    .full_rst_o  (full_rst_o),
    .periph_rst_o(periph_rst_o),
    .drive_o     (ext_rst_drive_o),
    .lock_o      (lock_o)
  );

endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk
  import rstctl_pkg::*;
#(
  parameter int unsigned TMO_BASE = 8,
  parameter int unsigned HOLD_CYC = 16
) (
  input logic                 clk,
  input logic                 por_n,
  input rst_state_e           st,
  input logic                 hw_req,
  input logic                 bus_busy_i,
  input logic                 opnd_end_i,
  input logic                 sw_rst_i,
  input logic [TMO_SEL_W-1:0] tmo_sel_i,
  input logic                 full_rst_o,
  input logic                 periph_rst_o,
  input logic                 ext_rst_drive_o,
  input logic                 lock_o
);

  int unsigned pend_cnt;
  int unsigned full_wid;
  int unsigned lim;

  assign lim = TMO_BASE << tmo_sel_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pend_cnt <= 0;
      full_wid <= 0;
    end else begin
      pend_cnt <= (st == ST_PEND) ? pend_cnt + 1 : 0;
      full_wid <= full_rst_o ? full_wid + 1 : 0;
    end
  end

  AST_UNLOCKED_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    !lock_o |-> full_rst_o) else $error("full reset low before lock"); // R1

  AST_IDLE_APPLY: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_RUN && hw_req && !bus_busy_i) |=> full_rst_o) else $error("idle request not applied"); // R3

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_PEND && bus_busy_i && !opnd_end_i && (pend_cnt + 1 < lim)) |=> !full_rst_o)
    else $error("reset broke into operand"); // R4

  AST_END_APPLY: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_PEND && opnd_end_i) |=> full_rst_o) else $error("end strobe not honoured"); // R4

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_PEND) |-> (pend_cnt < lim)) else $error("pending beyond timeout"); // R5

  AST_FULL_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(full_rst_o) |-> (full_wid >= HOLD_CYC)) else $error("full reset too short"); // R6

  AST_GAP_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ext_rst_drive_o) |=> (!ext_rst_drive_o && full_rst_o)) else $error("no release gap"); // R7

  AST_SW_SPARES: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_RUN && !hw_req && sw_rst_i) |=> (periph_rst_o && !full_rst_o))
    else $error("software reset touched full reset"); // R9

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    lock_o |=> lock_o) else $error("lock dropped"); // R10

endmodule

bind rstctl_top rstctl_chk #(
  .TMO_BASE(TMO_BASE),
  .HOLD_CYC(HOLD_CYC)
) i_chk (
  .clk            (clk),
  .por_n          (por_n),
  .st             (st),
  .hw_req         (hw_req),
  .bus_busy_i     (bus_busy_i),
  .opnd_end_i     (opnd_end_i),
  .sw_rst_i       (sw_rst_i),
  .tmo_sel_i      (tmo_sel_i),
  .full_rst_o     (full_rst_o),
  .periph_rst_o   (periph_rst_o),
  .ext_rst_drive_o(ext_rst_drive_o),
  .lock_o         (lock_o)
);

// File: tb/test_rstctl_top.sv
module test_rstctl_top;

  logic       clk = 1'b0;
  logic       por_n;
  logic       clk_stable;
  logic       ref_tick;
  logic       ext_hold;
  logic       ext_pin_n;
  logic       wdog;
  logic       dbl;
  logic       clk_loss;
  logic       sw;
  logic       busy;
  logic       oend;
  logic [1:0] sel;
  logic       full;
  logic       periph;
  logic       drive;
  logic       lock;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  // open-drain pin with pull-up
  assign ext_pin_n = ~(drive | ext_hold);

  rstctl_top i_rstctl_top (
    .clk            (clk),
    .por_n          (por_n),
    .clk_stable_i   (clk_stable),
    .ref_tick_i     (ref_tick),
    .ext_rst_in_n   (ext_pin_n),
    .wdog_rst_i     (wdog),
    .dbl_fault_i    (dbl),
    .clk_loss_i     (clk_loss),
    .sw_rst_i       (sw),
    .bus_busy_i     (busy),
    .opnd_end_i     (oend),
    .tmo_sel_i      (sel),
    .full_rst_o     (full),
    .periph_rst_o   (periph),
    .ext_rst_drive_o(drive),
    .lock_o         (lock)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // edge (counted from 1 after the request is driven) after which full rises
  function automatic int exp_rise(input int src, input bit bsy, input int k, input int s);
    int nr;
    int lim;
    nr  = (src >= 2) ? 3 : 1;
    lim = 8 << s;
    if (!bsy) return nr;
    return nr + (((k + 1) < lim) ? (k + 1) : lim);
  endfunction

  task automatic run_hw(input int src, input bit bsy, input int k, input int s, input string tag);
    int got;
    int nr;
    int w_full;
    int w_drv;
    got = 0;
    nr  = (src >= 2) ? 3 : 1;
    @(negedge clk);
    sel  = s[1:0];
    busy = bsy;
    case (src)
      0: wdog = 1'b1;
      1: dbl = 1'b1;
      2: ext_hold = 1'b1;
      default: clk_loss = 1'b1;
    endcase
    for (int n = 1; n <= 200; n++) begin
      @(posedge clk); #1;
      if (full) begin
        got = n;
        break;
      end
      @(negedge clk);
      wdog = 1'b0;
      dbl  = 1'b0;
      oend = bsy && ((n + 1) == (nr + k + 1));
    end
    chk(tag, got, exp_rise(src, bsy, k, s));
    w_full = 1;
    w_drv  = drive ? 1 : 0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      wdog = (w_full == 3);   // R11: request during reset
      dbl = 1'b0; ext_hold = 1'b0; clk_loss = 1'b0; busy = 1'b0; oend = 1'b0;
      @(posedge clk); #1;
      if (!full) break;
      w_full++;
      if (drive) w_drv++;
    end
    @(negedge clk);
    wdog = 1'b0;
    chk("R6 R11 full width", w_full, 18);
    chk("R7 drive width", w_drv, 16);
    chk("R10 lock kept", lock, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_sw();
    int w;
    @(negedge clk);
    sw = 1'b1;
    @(posedge clk); #1;
    chk("R9 periph on", periph, 1);
    chk("R9 full off", full, 0);
    w = 1;
    @(negedge clk);
    sw = 1'b0;
    for (int n = 0; n < 40; n++) begin
      @(posedge clk); #1;
      if (!periph) break;
      w++;
      if (full || drive) chk("R9 no full/drive", 1, 0);
    end
    chk("R9 periph width", w, 16);
    chk("R9 lock kept", lock, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int src;
    int bsy;
    int s;
    int k;
    string tag;
    void'($urandom(32'd4711));
    por_n = 1'b0; clk_stable = 1'b0; ref_tick = 1'b1; ext_hold = 1'b0;
    wdog = 1'b0; dbl = 1'b0; clk_loss = 1'b0; sw = 1'b0; busy = 1'b0;
    oend = 1'b0; sel = 2'd0;
    #1;
    chk("R1 full in por", full, 1);
    chk("R1 periph in por", periph, 1);
    chk("R1 drive in por", drive, 1);
    chk("R1 lock in por", lock, 0);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chk("R2 ticks ignored before stable", lock, 0);
    chk("R1 full held", full, 1);
    @(negedge clk);
    clk_stable = 1'b1;
    @(posedge clk);
    repeat (327) @(posedge clk);
    #1;
    chk("R2 lock before 328th tick", lock, 0);
    @(posedge clk); #1;
    chk("R2 lock at 328th tick", lock, 1);
    chk("R7 pin released in gap", drive, 0);
    chk("R1 full in gap", full, 1);
    @(posedge clk); #1;
    chk("R1 full gap 2", full, 1);
    @(posedge clk); #1;
    chk("R1 full released", full, 0);
    chk("R7 sensed pin ignored in gap", full, 0);
    repeat (3) @(negedge clk);

    // directed corners
    run_hw(0, 1'b0, 0, 0, "R3 wdog idle");
    run_hw(1, 1'b0, 0, 0, "R3 dbl idle");
    run_hw(2, 1'b0, 0, 0, "R8 pin idle");
    run_hw(3, 1'b0, 0, 0, "R8 clkloss idle");
    run_hw(0, 1'b1, 5, 3, "R4 end strobe");
    run_hw(1, 1'b1, 0, 0, "R4 end first cycle");
    run_hw(0, 1'b1, 100, 0, "R5 timeout 8");
    run_hw(2, 1'b1, 100, 3, "R5 timeout 64");
    run_hw(0, 1'b1, 15, 1, "R5 end equals timeout");
    run_hw(3, 1'b1, 14, 1, "R4 end one before timeout");
    run_sw();

    // random mix
    for (int it = 0; it < 24; it++) begin
      src = $urandom_range(0, 3);
      bsy = $urandom_range(0, 1);
      s   = $urandom_range(0, 3);
      k   = $urandom_range(0, 70);
      if (bsy != 0) tag = ((k + 1) < (8 << s)) ? "R4 random" : "R5 random";
      else          tag = (src >= 2) ? "R8 random" : "R3 random";
      run_hw(src, bsy[0], k, s, tag);
      if ((it % 6) == 5) run_sw();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule